// File: doc/BRIEF.md
# Nibble Accumulator and Stacked Index Registers

This block is the register section of a 4-bit processor datapath. It keeps an accumulator with a carry flip-flop, a B sub-accumulator that can also count, and two address registers, X and Y. X addresses the RAM file and Y addresses the RAM digit. Each address register has a shadow register, and one exchange operation swaps the register with its shadow. Software uses this to stack an address or to extend the addressing range. The ALU, the RAM and instruction decoding are outside the block.

Each cycle the block takes a 4-bit ALU result, the ALU carry-out, a destination code and a set of control strobes. The ALU result is written into at most one destination. At the same time the carry can be forced, the accumulator and carry can rotate as a 5-bit ring, B can count, and Y can step up or down. Y can therefore advance while a result goes to another register, which suits arithmetic over several digits. When several writes aim at one register in a cycle, an exchange wins over an ALU load, and an ALU load wins over a count or step.

Top module: `nibble_regfile`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, carry, B, X, Y and both shadow registers to zero.
- R2: Destination code 1 loads the ALU result into the accumulator and the ALU carry-out into carry in the same cycle. This load overrides any rotate or carry strobe in that cycle.
- R3: The carry set strobe makes carry 1 and the carry clear strobe makes it 0. If both are raised, set wins. The carry-test output always shows the current carry.
- R4: Rotate-left gives accumulator = {acc[2:0], carry} and carry = acc[3]. Rotate-right gives accumulator = {carry, acc[3:1]} and carry = acc[0]. If both are raised, left wins. A rotate overrides the carry strobes.
- R5: Destination code 2 loads B, 3 loads X and 4 loads Y. Codes 0, 5, 6 and 7 write no register.
- R6: B increments or decrements modulo 16. If both strobes are raised, increment wins. A count is suppressed in any cycle that loads B.
- R7: The terminal-count output is high in a cycle where a count actually takes place and B wraps: B is 15 on an increment, or 0 on a decrement.
- R8: The X exchange swaps X and its shadow in a single clock. It overrides a load of X in the same cycle.
- R9: The Y exchange swaps Y and its shadow in a single clock. It overrides both a load of Y and a Y step in the same cycle.
- R10: The Y step strobes increment or decrement Y modulo 16 (increment wins), including in cycles that load another destination. A load of Y suppresses the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | 4 | ALU result nibble |
| alu_cout | input | 1 | ALU carry-out |
| dest_sel | input | 3 | Destination for the ALU result (0 none, 1 accumulator, 2 B, 3 X, 4 Y) |
| carry_set | input | 1 | Force carry to 1 |
| carry_clr | input | 1 | Force carry to 0 |
| rot_left | input | 1 | Rotate accumulator and carry left |
| rot_right | input | 1 | Rotate accumulator and carry right |
| b_inc | input | 1 | Increment B |
| b_dec | input | 1 | Decrement B |
| x_swap | input | 1 | Exchange X with its shadow |
| y_swap | input | 1 | Exchange Y with its shadow |
| y_inc | input | 1 | Step Y up |
| y_dec | input | 1 | Step Y down |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flip-flop |
| carry_test | output | 1 | Carry-test flag |
| b_val | output | 4 | B register |
| b_tc | output | 1 | B wrap/terminal-count flag |
| x_addr | output | 4 | X register (RAM file address) |
| spx_val | output | 4 | X shadow register |
| y_addr | output | 4 | Y register (RAM digit address) |
| spy_val | output | 4 | Y shadow register |

## Verification
Loads are checked with a distinct value and carry-out for each destination, so a write that lands in the wrong register is detected. Rotates start from asymmetric patterns such as 1001 with carry 1 and 0100 with carry 0, so a ring in the wrong direction, or a missing carry path, gives a different value. Conflicting strobes are raised together (set with clear, left with right, increment with decrement, exchange with load and step) to check every priority. B and Y are run across 0 and 15 in both directions to check wrapping and the terminal-count flag.

// File: rtl/nibregs_pkg.sv
package nibregs_pkg;
    parameter int unsigned NIB_W = 4;
    localparam int unsigned RING_W = NIB_W + 1;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_ACC  = 3'd1,
        DST_B    = 3'd2,
        DST_X    = 3'd3,
        DST_Y    = 3'd4
    } dest_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Ring result layout: {new_carry, new_acc}
    function automatic logic [RING_W-1:0] ring_left(nib_t a, logic c);
        return {a[NIB_W-1], a[NIB_W-2:0], c};
    endfunction

    function automatic logic [RING_W-1:0] ring_right(nib_t a, logic c);
        return {a[0], c, a[NIB_W-1:1]};
    endfunction

    // Upward request has precedence over downward
    function automatic step_e pick_step(logic up, logic dn);
        if (up)      return STEP_UP;
        else if (dn) return STEP_DOWN;
        else         return STEP_HOLD;
    endfunction

    function automatic nib_t apply_step(nib_t v, step_e s);
        case (s)
            STEP_UP:   return v + nib_t'(1);
            STEP_DOWN: return v - nib_t'(1);
            default:   return v;
        endcase
    endfunction
endpackage

// File: rtl/acc_carry_unit.sv
module acc_carry_unit
    import nibregs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  nib_t ld_val,
    input  logic ld_cout,
    input  logic c_set,
    input  logic c_clr,
    input  logic rl,
    input  logic rr,
    output nib_t acc_q,
    output logic c_q
);
    typedef struct packed {
        logic c;
        nib_t a;
    } ring_t;

    ring_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (ld)        nxt = '{c: ld_cout, a: ld_val};
        else if (rl)   nxt = ring_t'(ring_left(cur.a, cur.c));
        else if (rr)   nxt = ring_t'(ring_right(cur.a, cur.c));
        else if (c_set) nxt.c = 1'b1;
        else if (c_clr) nxt.c = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign acc_q = cur.a;
    assign c_q   = cur.c;

    // R2
    alu_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> (acc_q == $past(ld_val) && c_q == $past(ld_cout)));

    // R4
    rot_left_chk: assert property (@(posedge clk) disable iff (rst)
        (rl && !ld) |=> (acc_q[0] == $past(c_q) && c_q == $past(acc_q[NIB_W-1])));

    // R4
    rot_right_chk: assert property (@(posedge clk) disable iff (rst)
        (rr && !rl && !ld) |=> (acc_q[NIB_W-1] == $past(c_q) && c_q == $past(acc_q[0])));

    // R3
    carry_set_chk: assert property (@(posedge clk) disable iff (rst)
        (c_set && !ld && !rl && !rr) |=> c_q);
endmodule

// File: rtl/b_counter.sv
module b_counter
    import nibregs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  nib_t ld_val,
    input  logic up,
    input  logic dn,
    output nib_t val_q,
    output logic tc
);
    step_e st;

    always_comb begin
        st = ld ? STEP_HOLD : pick_step(up, dn);
        tc = (st == STEP_UP   && val_q == '1) ||
             (st == STEP_DOWN && val_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)     val_q <= '0;
        else if (ld) val_q <= ld_val;
        else         val_q <= apply_step(val_q, st);
    end

    // R6
    b_count_up_chk: assert property (@(posedge clk) disable iff (rst)
        (up && !ld) |=> val_q == $past(val_q) + nib_t'(1));

    // R7
    b_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tc |=> (val_q == '0 || val_q == '1));
endmodule

// File: rtl/index_pair.sv
module index_pair
    import nibregs_pkg::*;
#(
    parameter bit HAS_STEP = 1'b0
)(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  nib_t ld_val,
    input  logic swap,
    input  logic up,
    input  logic dn,
    output nib_t main_q,
    output nib_t shadow_q
);
    nib_t stepped;

    generate
        if (HAS_STEP) begin : g_step
            always_comb stepped = apply_step(main_q, pick_step(up, dn));
        end else begin : g_hold
            logic unused_steps;
            always_comb begin
                unused_steps = up ^ dn;
                stepped      = main_q;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q   <= '0;
            shadow_q <= '0;
        end else if (swap) begin
            main_q   <= shadow_q;
            shadow_q <= main_q;
        end else if (ld) begin
            main_q   <= ld_val;
        end else begin
            main_q   <= stepped;
        end
    end

    // R8 R9
    swap_atomic_chk: assert property (@(posedge clk) disable iff (rst)
        swap |=> (main_q == $past(shadow_q) && shadow_q == $past(main_q)));

    // R5
    shadow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !swap |=> $stable(shadow_q));
endmodule

// File: rtl/nibble_regfile.sv
module nibble_regfile
    import nibregs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] alu_res,
    input  logic       alu_cout,
    input  logic [2:0] dest_sel,
    input  logic       carry_set,
    input  logic       carry_clr,
    input  logic       rot_left,
    input  logic       rot_right,
    input  logic       b_inc,
    input  logic       b_dec,
    input  logic       x_swap,
    input  logic       y_swap,
    input  logic       y_inc,
    input  logic       y_dec,
    output logic [3:0] acc,
    output logic       carry,
    output logic       carry_test,
    output logic [3:0] b_val,
    output logic       b_tc,
    output logic [3:0] x_addr,
    output logic [3:0] spx_val,
    output logic [3:0] y_addr,
    output logic [3:0] spy_val
);
    logic ld_acc, ld_b, ld_x, ld_y;

    always_comb begin
        ld_acc = (dest_sel == DST_ACC);
        ld_b   = (dest_sel == DST_B);
        ld_x   = (dest_sel == DST_X);
        ld_y   = (dest_sel == DST_Y);
    end

    acc_carry_unit u_acc (
        .clk(clk), .rst(rst), .ld(ld_acc), .ld_val(alu_res), .ld_cout(alu_cout),
        .c_set(carry_set), .c_clr(carry_clr), .rl(rot_left), .rr(rot_right),
        .acc_q(acc), .c_q(carry)
    );

    b_counter u_b (
        .clk(clk), .rst(rst), .ld(ld_b), .ld_val(alu_res),
        .up(b_inc), .dn(b_dec), .val_q(b_val), .tc(b_tc)
    );

    index_pair #(.HAS_STEP(1'b0)) u_x (
        .clk(clk), .rst(rst), .ld(ld_x), .ld_val(alu_res), .swap(x_swap),
        .up(1'b0), .dn(1'b0), .main_q(x_addr), .shadow_q(spx_val)
    );

    index_pair #(.HAS_STEP(1'b1)) u_y (
        .clk(clk), .rst(rst), .ld(ld_y), .ld_val(alu_res), .swap(y_swap),
        .up(y_inc), .dn(y_dec), .main_q(y_addr), .shadow_q(spy_val)
    );

    assign carry_test = carry;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc == '0 && !carry && b_val == '0 && x_addr == '0 &&
                 spx_val == '0 && y_addr == '0 && spy_val == '0));

    // R10
    y_step_chk: assert property (@(posedge clk) disable iff (rst)
        (y_inc && !y_swap && !ld_y) |=> y_addr == $past(y_addr) + 4'd1);

    // R5
    x_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_x && !x_swap) |=> $stable(x_addr));
endmodule

// File: tb/nibble_regfile_test.sv
module nibble_regfile_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] alu_res;
    logic       alu_cout;
    logic [2:0] dest_sel;
    logic       carry_set, carry_clr, rot_left, rot_right;
    logic       b_inc, b_dec, x_swap, y_swap, y_inc, y_dec;
    logic [3:0] acc, b_val, x_addr, spx_val, y_addr, spy_val;
    logic       carry, carry_test, b_tc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    nibble_regfile uut (
        .clk(clk), .rst(rst), .alu_res(alu_res), .alu_cout(alu_cout),
        .dest_sel(dest_sel), .carry_set(carry_set), .carry_clr(carry_clr),
        .rot_left(rot_left), .rot_right(rot_right), .b_inc(b_inc), .b_dec(b_dec),
        .x_swap(x_swap), .y_swap(y_swap), .y_inc(y_inc), .y_dec(y_dec),
        .acc(acc), .carry(carry), .carry_test(carry_test), .b_val(b_val),
        .b_tc(b_tc), .x_addr(x_addr), .spx_val(spx_val), .y_addr(y_addr),
        .spy_val(spy_val)
    );

    // ctrl bits, MSB first: cs cc rl rr bi bd xs ys yi yd
    typedef struct packed {
        logic [3:0] alu;
        logic       cout;
        logic [2:0] dest;
        logic [9:0] ctrl;
        logic [3:0] e_acc;
        logic       e_c;
        logic [3:0] e_b;
        logic [3:0] e_x;
        logic [3:0] e_spx;
        logic [3:0] e_y;
        logic [3:0] e_spy;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{4'h9,1'b1,3'd1,10'b0000000000, 4'h9,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0}, // R2
        '{4'h3,1'b0,3'd2,10'b0000000000, 4'h9,1'b1,4'h3,4'h0,4'h0,4'h0,4'h0}, // R5
        '{4'hA,1'b0,3'd3,10'b0000000000, 4'h9,1'b1,4'h3,4'hA,4'h0,4'h0,4'h0}, // R5
        '{4'h6,1'b0,3'd4,10'b0000000000, 4'h9,1'b1,4'h3,4'hA,4'h0,4'h6,4'h0}, // R5
        '{4'h0,1'b0,3'd0,10'b0000001000, 4'h9,1'b1,4'h3,4'h0,4'hA,4'h6,4'h0}, // R8
        '{4'h0,1'b0,3'd0,10'b0000000100, 4'h9,1'b1,4'h3,4'h0,4'hA,4'h0,4'h6}, // R9
        '{4'h5,1'b0,3'd3,10'b0000000000, 4'h9,1'b1,4'h3,4'h5,4'hA,4'h0,4'h6}, // R5
        '{4'hF,1'b0,3'd3,10'b0000001000, 4'h9,1'b1,4'h3,4'hA,4'h5,4'h0,4'h6}, // R8
        '{4'h0,1'b0,3'd0,10'b0010000000, 4'h3,1'b1,4'h3,4'hA,4'h5,4'h0,4'h6}, // R4
        '{4'h0,1'b0,3'd0,10'b0001000000, 4'h9,1'b1,4'h3,4'hA,4'h5,4'h0,4'h6}, // R4
        '{4'h0,1'b0,3'd0,10'b0100000000, 4'h9,1'b0,4'h3,4'hA,4'h5,4'h0,4'h6}, // R3
        '{4'h0,1'b0,3'd0,10'b0001000000, 4'h4,1'b1,4'h3,4'hA,4'h5,4'h0,4'h6}, // R4
        '{4'h0,1'b0,3'd0,10'b1100000000, 4'h4,1'b1,4'h3,4'hA,4'h5,4'h0,4'h6}, // R3
        '{4'h0,1'b0,3'd0,10'b0100000000, 4'h4,1'b0,4'h3,4'hA,4'h5,4'h0,4'h6}, // R3
        '{4'h0,1'b0,3'd0,10'b0011000000, 4'h8,1'b0,4'h3,4'hA,4'h5,4'h0,4'h6}, // R4
        '{4'h2,1'b0,3'd1,10'b1010000000, 4'h2,1'b0,4'h3,4'hA,4'h5,4'h0,4'h6}, // R2
        '{4'h0,1'b0,3'd0,10'b0000100000, 4'h2,1'b0,4'h4,4'hA,4'h5,4'h0,4'h6}, // R6
        '{4'h0,1'b0,3'd0,10'b0000110000, 4'h2,1'b0,4'h5,4'hA,4'h5,4'h0,4'h6}, // R6
        '{4'h0,1'b0,3'd0,10'b0000010000, 4'h2,1'b0,4'h4,4'hA,4'h5,4'h0,4'h6}, // R6
        '{4'h0,1'b0,3'd2,10'b0000100000, 4'h2,1'b0,4'h0,4'hA,4'h5,4'h0,4'h6}, // R6
        '{4'h0,1'b0,3'd0,10'b0000010000, 4'h2,1'b0,4'hF,4'hA,4'h5,4'h0,4'h6}, // R6
        '{4'h0,1'b0,3'd0,10'b0000100000, 4'h2,1'b0,4'h0,4'hA,4'h5,4'h0,4'h6}, // R6
        '{4'h7,1'b1,3'd1,10'b0000000010, 4'h7,1'b1,4'h0,4'hA,4'h5,4'h1,4'h6}, // R10
        '{4'hC,1'b0,3'd2,10'b0000000001, 4'h7,1'b1,4'hC,4'hA,4'h5,4'h0,4'h6}, // R10
        '{4'h0,1'b0,3'd0,10'b0000000001, 4'h7,1'b1,4'hC,4'hA,4'h5,4'hF,4'h6}, // R10
        '{4'h0,1'b0,3'd0,10'b0000000010, 4'h7,1'b1,4'hC,4'hA,4'h5,4'h0,4'h6}, // R10
        '{4'h8,1'b0,3'd4,10'b0000000010, 4'h7,1'b1,4'hC,4'hA,4'h5,4'h8,4'h6}, // R10
        '{4'h1,1'b0,3'd4,10'b0000000110, 4'h7,1'b1,4'hC,4'hA,4'h5,4'h6,4'h8}, // R9
        '{4'hD,1'b1,3'd5,10'b0000000000, 4'h7,1'b1,4'hC,4'hA,4'h5,4'h6,4'h8}, // R5
        '{4'hE,1'b0,3'd7,10'b0000000000, 4'h7,1'b1,4'hC,4'hA,4'h5,4'h6,4'h8}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] a, input logic co, input logic [2:0] d,
                         input logic [9:0] c);
        alu_res  = a;
        alu_cout = co;
        dest_sel = d;
        {carry_set, carry_clr, rot_left, rot_right, b_inc, b_dec,
         x_swap, y_swap, y_inc, y_dec} = c;
    endtask

    task automatic check_state(input string req, input vec_t v);
        check(req, {acc, carry, b_val, x_addr, spx_val, y_addr, spy_val},
                   {v.e_acc, v.e_c, v.e_b, v.e_x, v.e_spx, v.e_y, v.e_spy});
    endtask

    initial begin
        rst = 1'b1;
        drive(4'h0, 1'b0, 3'd0, 10'b0);
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1", {acc, carry, b_val, x_addr, spx_val, y_addr, spy_val}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].alu, TBL[i].cout, TBL[i].dest, TBL[i].ctrl);
            @(negedge clk);
            check_state($sformatf("R2-table step %0d", i), TBL[i]);
        end

        // R3 carry-test output follows carry
        check("R3 carry_test", {31'b0, carry_test}, {31'b0, carry});

        // R7 terminal count: B is 0xC here; load 0 then check dec wrap
        drive(4'h0, 1'b0, 3'd2, 10'b0);
        @(negedge clk);
        drive(4'h0, 1'b0, 3'd0, 10'b0000010000);
        #1 check("R7 dec at 0", {31'b0, b_tc}, 32'd1);
        drive(4'h0, 1'b0, 3'd0, 10'b0000100000);
        #1 check("R7 inc at 0", {31'b0, b_tc}, 32'd0);
        drive(4'h0, 1'b0, 3'd2, 10'b0000010000);
        #1 check("R7 dec suppressed by load", {31'b0, b_tc}, 32'd0);
        @(negedge clk);
        check("R6 load beats dec", {28'b0, b_val}, 32'h0);
        drive(4'hF, 1'b0, 3'd2, 10'b0);
        @(negedge clk);
        drive(4'h0, 1'b0, 3'd0, 10'b0000100000);
        #1 check("R7 inc at 15", {31'b0, b_tc}, 32'd1);
        drive(4'h0, 1'b0, 3'd0, 10'b0000010000);
        #1 check("R7 dec at 15", {31'b0, b_tc}, 32'd0);
        drive(4'h0, 1'b0, 3'd0, 10'b0);
        #1 check("R7 idle", {31'b0, b_tc}, 32'd0);
        @(negedge clk);

        // R1 reset mid-run overrides simultaneous load and strobes
        rst = 1'b1;
        drive(4'h9, 1'b1, 3'd1, 10'b1000001100);
        @(negedge clk);
        check("R1 mid-run reset", {acc, carry, b_val, x_addr, spx_val, y_addr, spy_val}, 32'h0);
        rst = 1'b0;
        drive(4'h0, 1'b0, 3'd0, 10'b0);
        @(negedge clk);
        check("R1 stays clear", {acc, carry, b_val, x_addr, spx_val, y_addr, spy_val}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule